// File: doc/BRIEF.md
# Dual-Bank Out-of-Order Box-Sum Unit

This block returns the sum of a square pixel window, computed from an integral image held in two synchronous RAM banks. Even image rows live in bank 0 and odd rows in bank 1. A request names a window centre (x, y), a half-width w that may change on every request, and an index tag. The window covers the rows y-w+1 to y+w and the columns x-w+1 to x+w. The block reads the four corners (x±w, y±w) of the integral image and combines them into a single signed sum.

The rows y-w and y+w always have the same parity, so all four corner reads of a request land in one bank. The request is queued into that bank's address FIFO. Each FIFO drives only its own bank, and each bank has its own four-cycle summing engine. While both FIFOs hold work, two windows are summed in parallel. Results leave on two lanes, one per bank, and carry their tag, so the consumer restores the original order. Integral-image rows are loaded through a simple write port that routes each row to its bank by row parity.

Top module: `boxsum_dual_bank`

## Requirements
- R1: After reset, no lane reports a result and the request input is ready.
- R2: A request whose (y - w) is even is served by bank 0, and its result appears on lane 0 (bit 0 of `res_valid_o`, low slices of the tag and sum buses). An odd (y - w) goes to bank 1 and lane 1. An image write to row r is stored in bank r[0] at entry {r >> 1, column}.
- R3: The result equals I(x+w, y+w) - I(x-w, y+w) - I(x+w, y-w) + I(x-w, y-w), where I(col, row) is the written integral-image word taken as unsigned. The result is a DATA_W+2 bit two's-complement value. With w = 0 the result is zero.
- R4: Every result carries, unchanged, the tag given with its request.
- R5: Each lane returns its results in the order that the requests for its bank were accepted, and every accepted request yields exactly one result. Results on different lanes are not ordered relative to each other.
- R6: A lane produces at most one result every four cycles. While its FIFO stays non-empty, results follow exactly four cycles apart.
- R7: `req_ready_o` is low exactly when the FIFO of the bank that the offered request targets is full. A request that targets the other bank is ready at the same time if that bank's FIFO has room.
- R8: Requests that alternate between the banks are processed concurrently. N such requests finish well within the 4·N cycles that one bank would need.
- R9: While one bank has no queued work, its lane stays silent and the other bank keeps producing results at its full rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Integral-image write strobe |
| wr_row_i | input | ROW_W | Image row to write |
| wr_col_i | input | COL_W | Image column to write |
| wr_data_i | input | DATA_W | Integral-image word |
| req_valid_i | input | 1 | Window request offered |
| req_ready_o | output | 1 | Targeted FIFO has room |
| req_x_i | input | COL_W | Window centre column |
| req_y_i | input | ROW_W | Window centre row |
| req_w_i | input | HW_W | Window half-width |
| req_tag_i | input | TAG_W | Request index tag |
| res_valid_o | output | 2 | Result strobe per lane |
| res_tag_o | output | 2*TAG_W | Tag per lane, lane 0 in the low slice |
| res_sum_o | output | 2*SUM_W | Signed window sum per lane, lane 0 in the low slice |

## Verification
Some properties are checked by assertions on every cycle. Neither FIFO is ever pushed when full or popped when empty. Each engine visits the corners in the order A, B, C, D without gaps. An engine only addresses rows of its own parity. Results on a lane never come closer than four cycles apart. Other behaviour only the bench scenarios can show: the arithmetic value of each sum against a reference image, the returned tags, per-lane ordering, ready falling for one bank while staying high for the other, sustained four-cycle spacing with the opposite lane idle, and the speed-up when requests alternate between banks.

// File: rtl/boxsum_pkg.sv
package boxsum_pkg;

  typedef enum logic [1:0] {
    CRN_A = 2'd0,  // (x+w, y+w)  +
    CRN_B = 2'd1,  // (x-w, y+w)  -
    CRN_C = 2'd2,  // (x+w, y-w)  -
    CRN_D = 2'd3   // (x-w, y-w)  +
  } corner_e;

  function automatic logic corner_neg(corner_e c);
    return (c == CRN_B) || (c == CRN_C);
  endfunction

  function automatic logic corner_hi_col(corner_e c);
    return (c == CRN_A) || (c == CRN_C);
  endfunction

  function automatic logic corner_hi_row(corner_e c);
    return (c == CRN_A) || (c == CRN_B);
  endfunction

endpackage

// File: rtl/boxsum_fifo.sv
module boxsum_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_i)  rptr_q <= ptr_inc(rptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && full_o));  // R7
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && empty_o));  // R5

endmodule

// File: rtl/boxsum_ram.sv
module boxsum_ram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

endmodule

// File: rtl/boxsum_engine.sv
module boxsum_engine
  import boxsum_pkg::*;
#(
  parameter int BANK   = 0,
  parameter int COL_W  = 4,
  parameter int ROW_W  = 4,
  parameter int HW_W   = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  parameter int SUM_W  = DATA_W + 2,
  parameter int ADDR_W = ROW_W - 1 + COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ent_valid_i,
  input  logic [COL_W-1:0]        ent_x_i,
  input  logic [ROW_W-1:0]        ent_y_i,
  input  logic [HW_W-1:0]         ent_w_i,
  input  logic [TAG_W-1:0]        ent_tag_i,
  output logic                    pop_o,
  output logic                    rd_en_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic                    res_valid_o,
  output logic [TAG_W-1:0]        res_tag_o,
  output logic signed [SUM_W-1:0] res_sum_o
);
  // address stage
  logic             busy_q;
  corner_e          crn_q;
  logic [COL_W-1:0] x_q;
  logic [ROW_W-1:0] y_q;
  logic [HW_W-1:0]  w_q;
  logic [TAG_W-1:0] tag_q;
  logic [COL_W-1:0] col_sel;
  logic [ROW_W-1:0] row_sel;

  // data stage
  logic             dv_q;
  corner_e          dcrn_q;
  logic [TAG_W-1:0] dtag_q;
  logic signed [SUM_W-1:0] acc_q, term, base, acc_nxt;

  assign pop_o = ent_valid_i && (!busy_q || crn_q == CRN_D);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      crn_q  <= CRN_A;
      x_q    <= '0;
      y_q    <= '0;
      w_q    <= '0;
      tag_q  <= '0;
    end else if (pop_o) begin
      busy_q <= 1'b1;
      crn_q  <= CRN_A;
      x_q    <= ent_x_i;
      y_q    <= ent_y_i;
      w_q    <= ent_w_i;
      tag_q  <= ent_tag_i;
    end else if (busy_q) begin
      if (crn_q == CRN_D) busy_q <= 1'b0;
      else                crn_q  <= corner_e'(crn_q + 2'd1);
    end
  end

  always_comb begin
    col_sel = corner_hi_col(crn_q) ? x_q + COL_W'(w_q) : x_q - COL_W'(w_q);
    row_sel = corner_hi_row(crn_q) ? y_q + ROW_W'(w_q) : y_q - ROW_W'(w_q);
  end

  assign rd_en_o   = busy_q;
  assign rd_addr_o = {row_sel[ROW_W-1:1], col_sel};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q   <= 1'b0;
      dcrn_q <= CRN_A;
      dtag_q <= '0;
    end else begin
      dv_q   <= busy_q;
      dcrn_q <= crn_q;
      dtag_q <= tag_q;
    end
  end

  always_comb begin
    term    = $signed({{(SUM_W-DATA_W){1'b0}}, rd_data_i});
    base    = (dcrn_q == CRN_A) ? '0 : acc_q;
    acc_nxt = corner_neg(dcrn_q) ? base - term : base + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      res_valid_o <= 1'b0;
      res_tag_o   <= '0;
      res_sum_o   <= '0;
    end else begin
      res_valid_o <= dv_q && (dcrn_q == CRN_D);
      if (dv_q) acc_q <= acc_nxt;
      if (dv_q && dcrn_q == CRN_D) begin
        res_sum_o <= acc_nxt;
        res_tag_o <= dtag_q;
      end
    end
  end

  AST_BANK_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (row_sel[0] == 1'(BANK)));  // R2
  AST_CORNER_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_q && dcrn_q != CRN_A) |-> ($past(dv_q) && (2'($past(dcrn_q)) + 2'd1 == 2'(dcrn_q))));  // R3
  AST_RES_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);  // R6
  AST_RES_SPACING_3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !($past(res_valid_o, 2) || $past(res_valid_o, 3)));  // R6

endmodule

// File: rtl/boxsum_dual_bank.sv
module boxsum_dual_bank #(
  parameter int COL_W      = 4,
  parameter int ROW_W      = 4,
  parameter int HW_W       = 2,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int SUM_W      = DATA_W + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ROW_W-1:0]     wr_row_i,
  input  logic [COL_W-1:0]     wr_col_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [COL_W-1:0]     req_x_i,
  input  logic [ROW_W-1:0]     req_y_i,
  input  logic [HW_W-1:0]      req_w_i,
  input  logic [TAG_W-1:0]     req_tag_i,
  output logic [1:0]           res_valid_o,
  output logic [2*TAG_W-1:0]   res_tag_o,
  output logic [2*SUM_W-1:0]   res_sum_o
);
  localparam int NBANK  = 2;
  localparam int ADDR_W = ROW_W - 1 + COL_W;
  localparam int ENT_W  = COL_W + ROW_W + HW_W + TAG_W;

  logic             tgt;
  logic [NBANK-1:0] full, empty, push, pop;
  logic [ENT_W-1:0] ent_in;

  assign tgt         = req_y_i[0] ^ req_w_i[0];  // parity of y - w
  assign req_ready_o = !full[tgt];
  assign ent_in      = {req_x_i, req_y_i, req_w_i, req_tag_i};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [ENT_W-1:0]  ent_out;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              bank_we;
    logic signed [SUM_W-1:0] sum;

    assign push[b]  = req_valid_i && req_ready_o && (tgt == 1'(b));
    assign bank_we  = wr_en_i && (wr_row_i[0] == 1'(b));

    boxsum_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[b]),
      .data_i  (ent_in),
      .pop_i   (pop[b]),
      .data_o  (ent_out),
      .full_o  (full[b]),
      .empty_o (empty[b])
    );

    boxsum_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (bank_we),
      .waddr_i ({wr_row_i[ROW_W-1:1], wr_col_i}),
      .wdata_i (wr_data_i),
      .re_i    (rd_en),
      .raddr_i (rd_addr),
      .rdata_o (rd_data)
    );

    boxsum_engine #(
      .BANK(b), .COL_W(COL_W), .ROW_W(ROW_W), .HW_W(HW_W),
      .TAG_W(TAG_W), .DATA_W(DATA_W), .SUM_W(SUM_W), .ADDR_W(ADDR_W)
    ) u_eng (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ent_valid_i (!empty[b]),
      .ent_x_i     (ent_out[ENT_W-1 -: COL_W]),
      .ent_y_i     (ent_out[HW_W+TAG_W +: ROW_W]),
      .ent_w_i     (ent_out[TAG_W +: HW_W]),
      .ent_tag_i   (ent_out[TAG_W-1:0]),
      .pop_o       (pop[b]),
      .rd_en_o     (rd_en),
      .rd_addr_o   (rd_addr),
      .rd_data_i   (rd_data),
      .res_valid_o (res_valid_o[b]),
      .res_tag_o   (res_tag_o[b*TAG_W +: TAG_W]),
      .res_sum_o   (sum)
    );

    assign res_sum_o[b*SUM_W +: SUM_W] = sum;
  end

  AST_REQ_READY_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> req_ready_o);  // R1

endmodule

// File: tb/boxsum_dual_bank_tb.sv
module boxsum_dual_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 4, ROW_W = 4, HW_W = 2, DATA_W = 16, TAG_W = 6;
  localparam int SUM_W = DATA_W + 2;
  localparam int NCOL = 1 << COL_W, NROW = 1 << ROW_W;

  typedef struct {
    int                      tag;
    logic signed [SUM_W-1:0] sum;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ROW_W-1:0] wr_row = '0;
  logic [COL_W-1:0] wr_col = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic req_valid = 1'b0, req_ready;
  logic [COL_W-1:0] req_x = '0;
  logic [ROW_W-1:0] req_y = '0;
  logic [HW_W-1:0] req_w = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [1:0] res_valid;
  logic [2*TAG_W-1:0] res_tag;
  logic [2*SUM_W-1:0] res_sum;

  int checks = 0, errors = 0, cyc = 0, next_tag = 0, lfsr = 32'h1d3;
  exp_t q0[$], q1[$];
  logic burst_on = 1'b0, last0_ok = 1'b0;
  int last0 = 0, lane1_in_burst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  boxsum_dual_bank #(.COL_W(COL_W), .ROW_W(ROW_W), .HW_W(HW_W), .DATA_W(DATA_W),
                     .TAG_W(TAG_W), .FIFO_DEPTH(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col),
    .wr_data_i(wr_data), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_x_i(req_x), .req_y_i(req_y), .req_w_i(req_w), .req_tag_i(req_tag),
    .res_valid_o(res_valid), .res_tag_o(res_tag), .res_sum_o(res_sum));

  function automatic int img(int r, int c);
    return (r * 613 + c * 97 + r * c * 29 + 5) & 16'hFFFF;
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int x, int y, int w);
    exp_t e;
    e.tag = next_tag;
    e.sum = SUM_W'(img(y+w, x+w) - img(y+w, x-w) - img(y-w, x+w) + img(y-w, x-w));
    next_tag = (next_tag + 1) % (1 << TAG_W);
    @(negedge clk);
    req_valid = 1'b1; req_x = COL_W'(x); req_y = ROW_W'(y); req_w = HW_W'(w);
    req_tag = TAG_W'(e.tag);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    if (((y - w) & 1) == 0) q0.push_back(e); else q1.push_back(e);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rand_req(output int x, output int y, output int w);
    lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
    w = (lfsr >> 8) % 4;
    x = w + ((lfsr >> 12) % (NCOL - 2 * w));
    y = w + ((lfsr >> 20) % (NROW - 2 * w));
  endtask

  task automatic lane_result(int l);
    exp_t e;
    int tg;
    logic signed [SUM_W-1:0] s;
    tg = int'(res_tag[l*TAG_W +: TAG_W]);
    s  = res_sum[l*SUM_W +: SUM_W];
    if ((l == 0 && q0.size() == 0) || (l == 1 && q1.size() == 0)) begin
      check("R2 unexpected result on lane", 1'b0, l, -1);
      return;
    end
    e = (l == 0) ? q0.pop_front() : q1.pop_front();
    check("R4/R5 tag in lane order", tg == e.tag, tg, e.tag);
    check("R3 window sum", s == e.sum, int'(s), int'(e.sum));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid[0]) begin
        lane_result(0);
        if (burst_on) begin
          if (last0_ok) check("R6 back-to-back spacing", (cyc - last0) == 4, cyc - last0, 4);
          last0 = cyc; last0_ok = 1'b1;
        end
      end
      if (res_valid[1]) begin
        lane_result(1);
        if (burst_on) lane1_in_burst++;
      end
    end
  end

  task automatic drain(int n);
    repeat (n) @(negedge clk);
    check("R5 every request answered", (q0.size() + q1.size()) == 0, q0.size() + q1.size(), 0);
  endtask

  initial begin
    int x, y, w, t0;
    logic seen_low;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 ready after reset", req_ready == 1'b1, req_ready, 1);
    check("R1 no result after reset", res_valid == 2'b00, res_valid, 0);
    for (int r = 0; r < NROW; r++)
      for (int c = 0; c < NCOL; c++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = ROW_W'(r); wr_col = COL_W'(c); wr_data = DATA_W'(img(r, c));
      end
    @(negedge clk) wr_en = 1'b0;
    check("R1 idle during load", res_valid == 2'b00, res_valid, 0);

    // directed: R2 parity, R3 boundaries and w = 0
    send(5, 5, 1);    // y-w even -> lane 0
    send(7, 6, 1);    // y-w odd  -> lane 1
    send(8, 8, 0);    // zero window
    send(3, 3, 3);    // touches row/col 0
    send(12, 12, 3);  // touches row/col 15
    send(9, 10, 3);
    drain(40);

    // mixed stream
    for (int i = 0; i < 40; i++) begin rand_req(x, y, w); send(x, y, w); end
    drain(120);

    // burst on bank 0 only: R6, R9, then R7 probe
    burst_on = 1'b1; last0_ok = 1'b0; lane1_in_burst = 0;
    for (int i = 0; i < 10; i++) send(2 + i % 10, 4, 2);
    seen_low = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_x = 4'd6; req_y = 4'd6; req_w = 2'd2; req_tag = '0;
    for (int i = 0; i < 8 && !seen_low; i++) begin
      #1;
      if (!req_ready) seen_low = 1'b1; else @(negedge clk);
    end
    check("R7 ready low for full bank 0", seen_low, seen_low, 1);
    req_y = 4'd7;
    #1;
    check("R7 ready high for empty bank 1", req_ready == 1'b1, req_ready, 1);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    burst_on = 1'b0;
    check("R9 lane 1 silent during bank 0 burst", lane1_in_burst == 0, lane1_in_burst, 0);
    drain(10);

    // alternating banks: R8
    t0 = cyc;
    for (int i = 0; i < 16; i++) send(4 + i % 8, 5 + (i % 2), 1);
    while (q0.size() + q1.size() != 0 && cyc - t0 < 200) @(negedge clk);
    check("R8 parallel completion time", (cyc - t0) <= 4 * 8 + 12, cyc - t0, 4 * 8 + 12);
    drain(20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule